// File: doc/BRIEF.md
# Byte-Wide Instruction Sequencer Core

This block is a multi-cycle 8-bit processor core. It fetches one opcode at a time from a byte-wide memory port and classifies it by masking the byte and comparing the result against a small set of templates. It then executes one of a narrow group of operations: a no-op, register copies, memory loads and stores through the 16-bit pointer formed by the H and L registers, loads of an 8-bit immediate, an immediate add into the accumulator, and a stop. Seven general registers (B, C, D, E, H, L, A) and a flag register sit beside a 16-bit program counter.

The memory port is synchronous. A read request placed on the port in one cycle returns its byte on `mem_rdata` in the following cycle. A write is taken at the clock edge that ends the cycle in which `mem_wr` is high. The core is meant to sit beside a single-port RAM or ROM model. It stops in a terminal state either on the stop opcode or on any byte that matches no template, and it leaves that state only through reset.

Top module: `byte_core`

## Requirements
- R1: While reset is held, and on leaving it, `halted`, `illegal` and `flags` are 0 and no write is issued. The first fetch reads address 0x0000. All seven general registers start at 0x00, which can be seen by storing them through the pointer.
- R2: Each instruction begins with a fetch cycle that reads at PC, followed by a decode cycle with no bus activity. Opcode 0x00 is a no-op: it takes 2 cycles and advances PC by 1. Read and write are never active together.
- R3: An opcode of the form 01dddsss, with neither field equal to 6, copies register sss into register ddd in 2 cycles, and PC advances by 1. The field codes are 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 7=A.
- R4: An opcode of the form 01ddd110 with ddd not 6 reads the byte at address {H,L} in its third cycle and loads it into register ddd. It takes 4 cycles, and PC advances by 1.
- R5: An opcode of the form 01110sss with sss not 6 writes register sss to address {H,L} in its third cycle. It takes 3 cycles, and PC advances by 1.
- R6: An opcode of the form 00ddd110 reads the byte at PC+1 in its third cycle. PC advances by 2. When ddd is not 6, the byte goes into register ddd (4 cycles). When ddd is 6, the byte is written to {H,L} in a fifth cycle.
- R7: Opcode 0xC6 reads the byte at PC+1, adds it to A modulo 256 and leaves the sum in A. It takes 4 cycles, and PC advances by 2.
- R8: `flags` shows the F register: bit 7 = sum zero, bit 6 = 0, bit 5 = carry out of bit 3, bit 4 = carry out of bit 7, and bits 3:0 = 0. Only opcode 0xC6 changes it, and the new value appears in the cycle after that instruction's last cycle.
- R9: Opcode 0x76 stops the core. From the cycle after its decode, `halted` is 1 and no further reads or writes occur until reset.
- R10: Any opcode that matches none of the forms above raises `illegal` from the cycle after its decode. The core then issues no further reads or writes until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 16 | Memory address for the current read or write |
| mem_rd | output | 1 | Read request; data is returned the next cycle |
| mem_wr | output | 1 | Write strobe, taken at the end of the cycle |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| flags | output | 8 | Flag register contents |
| halted | output | 1 | Core stopped by the stop opcode |
| illegal | output | 1 | Core stopped on an unmatched opcode |

## Verification
The bench goes after the boundaries in the opcode map. Field code 6 has to turn a register copy into a pointer read or a pointer write. Opcode 0x76 has to stop the core rather than move memory to memory. 0x36 has to finish with an extra write cycle. A decoder that compared unmasked bytes, or that checked the immediate form before the copy form, would put the wrong address or the wrong number of cycles on the bus, and the cycle-by-cycle comparison against the reference model catches that. Three immediate adds are chosen to set the nibble carry alone, the full carry together with zero, and zero alone. A design that took the half carry from the wrong bit, or let other opcodes disturb F, shows a flag mismatch in the following cycle. A second run after reset stores registers that were never written, to expose stale or non-zero reset values, and ends on an unmatched byte to check that the core goes quiet.

// File: rtl/byte_core_pkg.sv
package byte_core_pkg;

  localparam int DW     = 8;
  localparam int AW     = 16;
  localparam int RCW    = 3;
  localparam int NREG   = 1 << RCW;
  localparam int NIB    = DW / 2;

  localparam logic [RCW-1:0] RC_MEM = 3'd6;
  localparam logic [RCW-1:0] RC_H   = 3'd4;
  localparam logic [RCW-1:0] RC_L   = 3'd5;
  localparam logic [RCW-1:0] RC_A   = 3'd7;

  localparam int FB_Z = 7;
  localparam int FB_N = 6;
  localparam int FB_H = 5;
  localparam int FB_C = 4;

  // template / mask pairs
  localparam logic [DW-1:0] T_NOP = 8'h00, M_NOP = 8'hFF;
  localparam logic [DW-1:0] T_MOV = 8'h40, M_MOV = 8'hC0;
  localparam logic [DW-1:0] T_IMM = 8'h06, M_IMM = 8'hC7;
  localparam logic [DW-1:0] T_ADD = 8'hC6, M_ADD = 8'hFF;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_IMM_RD, ST_IMM_USE,
    ST_HL_RD, ST_HL_USE, ST_HL_WR, ST_HALT, ST_FAULT
  } state_t;

  typedef enum logic [3:0] {
    K_NOP, K_MOV, K_LD_IND, K_ST_IND, K_HALT,
    K_LD_IMM, K_ST_IMM, K_ADD_IMM, K_BAD
  } kind_t;

  typedef struct packed {
    logic [DW-1:0] res;
    logic [DW-1:0] f;
  } add_t;

  function automatic logic op_match(logic [DW-1:0] op, logic [DW-1:0] tmpl,
                                    logic [DW-1:0] mask);
    return (op & mask) == tmpl;
  endfunction

  function automatic add_t add_with_flags(logic [DW-1:0] a, logic [DW-1:0] b);
    add_t          r;
    logic [DW:0]   wide;
    logic [NIB:0]  low;
    wide = {1'b0, a} + {1'b0, b};
    low  = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]};
    r.res      = wide[DW-1:0];
    r.f        = '0;
    r.f[FB_Z]  = (wide[DW-1:0] == '0);
    r.f[FB_N]  = 1'b0;
    r.f[FB_H]  = low[NIB];
    r.f[FB_C]  = wide[DW];
    return r;
  endfunction

endpackage

// File: rtl/byte_core_decode.sv
module byte_core_decode
  import byte_core_pkg::*;
(
  input  logic [DW-1:0]  op,
  output kind_t          kind,
  output logic [RCW-1:0] dst,
  output logic [RCW-1:0] src
);

  localparam int SRC_LSB = 0;
  localparam int DST_LSB = RCW;

  always_comb begin
    dst  = op[DST_LSB +: RCW];
    src  = op[SRC_LSB +: RCW];
    kind = K_BAD;
    if (op_match(op, T_NOP, M_NOP)) begin
      kind = K_NOP;
    end else if (op_match(op, T_MOV, M_MOV)) begin
      if (dst == RC_MEM && src == RC_MEM)  kind = K_HALT;
      else if (dst == RC_MEM)              kind = K_ST_IND;
      else if (src == RC_MEM)              kind = K_LD_IND;
      else                                 kind = K_MOV;
    end else if (op_match(op, T_IMM, M_IMM)) begin
      kind = (dst == RC_MEM) ? K_ST_IMM : K_LD_IMM;
    end else if (op_match(op, T_ADD, M_ADD)) begin
      kind = K_ADD_IMM;
    end
  end

endmodule

// File: rtl/byte_core_regs.sv
module byte_core_regs
  import byte_core_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [RCW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [RCW-1:0] raddr,
  output logic [DW-1:0]  rdata,
  output logic [DW-1:0]  acc,
  output logic [AW-1:0]  ptr
);

  logic [DW-1:0] bank [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == int'(RC_MEM)) begin : g_hole
      assign bank[i] = '0;
    end else begin : g_store
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                q <= '0;
        else if (we && waddr == RCW'(i))           q <= wdata;
      end
      assign bank[i] = q;
    end
  end

  assign rdata = bank[raddr];
  assign acc   = bank[RC_A];
  assign ptr   = {bank[RC_H], bank[RC_L]};

endmodule

// File: rtl/byte_core_alu.sv
module byte_core_alu
  import byte_core_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] sum,
  output logic [DW-1:0] f_new
);

  add_t r;

  always_comb begin
    r     = add_with_flags(a, b);
    sum   = r.res;
    f_new = r.f;
  end

endmodule

// File: rtl/byte_core.sv
module byte_core
  import byte_core_pkg::*;
#(
  parameter logic [15:0] RESET_PC = 16'h0000
)(
  input  logic          clk,
  input  logic          rst_n,
  output logic [15:0]   mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic [7:0]    flags,
  output logic          halted,
  output logic          illegal
);

  state_t         st, st_nx;
  logic [AW-1:0]  pc_q;
  logic [DW-1:0]  ir_q, imm_q, f_q;

  logic           in_dec;
  logic [DW-1:0]  op_now;
  kind_t          kind;
  logic [RCW-1:0] dst, src;

  logic           rf_we;
  logic [RCW-1:0] rf_waddr;
  logic [DW-1:0]  rf_wdata, rf_src, acc;
  logic [AW-1:0]  ptr;
  logic [DW-1:0]  sum, f_new;

  // named events for the checker
  logic           fetch_go;
  logic           alu_we;
  logic [1:0]     pc_step;
  logic           imm_take;

  assign in_dec   = (st == ST_DECODE);
  assign op_now   = in_dec ? mem_rdata : ir_q;
  assign fetch_go = (st == ST_FETCH);
  assign alu_we   = (st == ST_IMM_USE) && (kind == K_ADD_IMM);
  assign imm_take = (st == ST_IMM_USE) && (kind == K_ST_IMM);

  byte_core_decode u_dec (
    .op   (op_now),
    .kind (kind),
    .dst  (dst),
    .src  (src)
  );

  byte_core_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .raddr (src),
    .rdata (rf_src),
    .acc   (acc),
    .ptr   (ptr)
  );

  byte_core_alu u_alu (
    .a     (acc),
    .b     (mem_rdata),
    .sum   (sum),
    .f_new (f_new)
  );

  // next state and PC step
  always_comb begin
    st_nx   = st;
    pc_step = 2'd0;
    unique case (st)
      ST_FETCH:   st_nx = ST_DECODE;
      ST_DECODE: begin
        pc_step = (kind == K_BAD) ? 2'd0 : 2'd1;
        unique case (kind)
          K_NOP, K_MOV:                 st_nx = ST_FETCH;
          K_LD_IND:                     st_nx = ST_HL_RD;
          K_ST_IND:                     st_nx = ST_HL_WR;
          K_HALT:                       st_nx = ST_HALT;
          K_LD_IMM, K_ST_IMM, K_ADD_IMM: st_nx = ST_IMM_RD;
          default:                      st_nx = ST_FAULT;
        endcase
      end
      ST_IMM_RD:  st_nx = ST_IMM_USE;
      ST_IMM_USE: begin
        pc_step = 2'd1;
        st_nx   = (kind == K_ST_IMM) ? ST_HL_WR : ST_FETCH;
      end
      ST_HL_RD:   st_nx = ST_HL_USE;
      ST_HL_USE:  st_nx = ST_FETCH;
      ST_HL_WR:   st_nx = ST_FETCH;
      ST_HALT:    st_nx = ST_HALT;
      default:    st_nx = ST_FAULT;
    endcase
  end

  // register write port
  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = dst;
    rf_wdata = mem_rdata;
    unique case (st)
      ST_DECODE: begin
        rf_we    = (kind == K_MOV);
        rf_wdata = rf_src;
      end
      ST_IMM_USE: begin
        if (kind == K_LD_IMM) begin
          rf_we = 1'b1;
        end else if (kind == K_ADD_IMM) begin
          rf_we    = 1'b1;
          rf_waddr = RC_A;
          rf_wdata = sum;
        end
      end
      ST_HL_USE: rf_we = 1'b1;
      default:   rf_we = 1'b0;
    endcase
  end

  // memory port
  always_comb begin
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = pc_q;
    mem_wdata = rf_src;
    unique case (st)
      ST_FETCH, ST_IMM_RD: mem_rd = 1'b1;
      ST_HL_RD: begin
        mem_rd   = 1'b1;
        mem_addr = ptr;
      end
      ST_HL_WR: begin
        mem_wr    = 1'b1;
        mem_addr  = ptr;
        mem_wdata = (kind == K_ST_IMM) ? imm_q : rf_src;
      end
      default: mem_rd = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_FETCH;
      pc_q  <= RESET_PC;
      ir_q  <= '0;
      imm_q <= '0;
      f_q   <= '0;
    end else begin
      st   <= st_nx;
      pc_q <= pc_q + AW'(pc_step);
      if (in_dec)   ir_q  <= mem_rdata;
      if (imm_take) imm_q <= mem_rdata;
      if (alu_we)   f_q   <= f_new;
    end
  end

  assign flags   = f_q;
  assign halted  = (st == ST_HALT);
  assign illegal = (st == ST_FAULT);

endmodule

// File: rtl/byte_core_chk.sv
module byte_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic [7:0] flags,
  input logic       halted,
  input logic       illegal,
  input logic       fetch_go,
  input logic       alu_we
);

  p_rw_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_decode_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_go |=> (!mem_rd && !mem_wr));

  p_flag_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[3:0] == 4'h0) && !flags[6]);

  p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !alu_we |=> $stable(flags));

  p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !mem_rd && !mem_wr));

  p_fault_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> (illegal && !mem_rd && !mem_wr));

  p_stop_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(halted && illegal));

endmodule

bind byte_core byte_core_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .flags    (flags),
  .halted   (halted),
  .illegal  (illegal),
  .fetch_go (fetch_go),
  .alu_we   (alu_we)
);

// File: tb/byte_core_test.sv
module byte_core_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;
  logic [7:0]  flags;
  logic        halted, illegal;

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 1'b0;

  byte_core uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .flags     (flags),
    .halted    (halted),
    .illegal   (illegal)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural memory seen by the core
  logic [7:0] mem  [0:65535];
  // model's private copy
  logic [7:0] rmem [0:65535];

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
  end

  // ---------------- reference model ----------------
  typedef struct {
    bit    rd;
    bit    wr;
    int    addr;
    int    wd;
    int    f;
    bit    hl;
    bit    il;
    string tag;
  } ev_t;

  ev_t q[$];
  int  rg[8];
  int  rpc, rf;
  bit  mhalt, mfault;

  task automatic push(bit rd, bit wr, int addr, int wd, string tag);
    ev_t e;
    e.rd = rd; e.wr = wr; e.addr = addr; e.wd = wd;
    e.f = rf; e.hl = mhalt; e.il = mfault; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) rg[i] = 0;
    rpc = 0; rf = 0; mhalt = 0; mfault = 0;
    q.delete();
  endtask

  task automatic model_step();
    int op, d, s, hl, imm, tot;
    if (mhalt || mfault) begin
      push(0, 0, 0, 0, mhalt ? "R9" : "R10");
      return;
    end
    op = int'(rmem[rpc[15:0]]);
    d  = (op / 8) % 8;
    s  = op % 8;
    hl = rg[4] * 256 + rg[5];
    if (op == 0) begin
      push(1, 0, rpc, 0, "R2"); push(0, 0, 0, 0, "R2");
      rpc = rpc + 1;
    end else if (op / 64 == 1) begin
      if (op == 8'h76) begin
        push(1, 0, rpc, 0, "R9"); push(0, 0, 0, 0, "R9");
        rpc = rpc + 1; mhalt = 1;
      end else if (d == 6) begin
        push(1, 0, rpc, 0, "R5"); push(0, 0, 0, 0, "R5");
        push(0, 1, hl, rg[s], "R5");
        rmem[hl[15:0]] = rg[s][7:0];
        rpc = rpc + 1;
      end else if (s == 6) begin
        push(1, 0, rpc, 0, "R4"); push(0, 0, 0, 0, "R4");
        push(1, 0, hl, 0, "R4"); push(0, 0, 0, 0, "R4");
        rg[d] = int'(rmem[hl[15:0]]);
        rpc = rpc + 1;
      end else begin
        push(1, 0, rpc, 0, "R3"); push(0, 0, 0, 0, "R3");
        rg[d] = rg[s];
        rpc = rpc + 1;
      end
    end else if (op % 8 == 6 && op < 64) begin
      imm = int'(rmem[(rpc + 1) % 65536]);
      push(1, 0, rpc, 0, "R6"); push(0, 0, 0, 0, "R6");
      push(1, 0, (rpc + 1) % 65536, 0, "R6"); push(0, 0, 0, 0, "R6");
      if (d == 6) begin
        push(0, 1, hl, imm, "R6");
        rmem[hl[15:0]] = imm[7:0];
      end else begin
        rg[d] = imm;
      end
      rpc = rpc + 2;
    end else if (op == 8'hC6) begin
      imm = int'(rmem[(rpc + 1) % 65536]);
      push(1, 0, rpc, 0, "R7"); push(0, 0, 0, 0, "R7");
      push(1, 0, (rpc + 1) % 65536, 0, "R7"); push(0, 0, 0, 0, "R7");
      tot = rg[7] + imm;
      rf = 0;
      if (tot % 256 == 0)              rf += 128;
      if ((rg[7] % 16) + (imm % 16) > 15) rf += 32;
      if (tot > 255)                   rf += 16;
      rg[7] = tot % 256;
      rpc = rpc + 2;
    end else begin
      push(1, 0, rpc, 0, "R10"); push(0, 0, 0, 0, "R10");
      mfault = 1;
    end
    rpc = rpc % 65536;
  endtask

  // ---------------- checking ----------------
  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      ev_t e;
      bit  ok;
      if (q.size() == 0) model_step();
      e  = q.pop_front();
      ok = (mem_rd == e.rd) && (mem_wr == e.wr);
      if ((e.rd || e.wr) && int'(mem_addr) != e.addr) ok = 0;
      if (e.wr && int'(mem_wdata) != e.wd) ok = 0;
      check(ok, e.tag, "bus cycle (addr)", {mem_rd, mem_wr, mem_addr},
            {e.rd, e.wr, e.addr[15:0]});
      if (e.wr)
        check(int'(mem_wdata) == e.wd, e.tag, "write data", int'(mem_wdata), e.wd);
      check(int'(flags) == e.f, "R8", "flags", int'(flags), e.f);
      check(halted == e.hl, "R9", "halted", int'(halted), int'(e.hl));
      check(illegal == e.il, "R10", "illegal", int'(illegal), int'(e.il));
    end
  end

  // ---------------- programs ----------------
  logic [7:0] prog1 [36] = '{
    8'h00, 8'h3E, 8'h0F, 8'hC6, 8'h01, 8'hC6, 8'hF0, 8'hC6, 8'h00,
    8'h06, 8'h12, 8'h0E, 8'h34, 8'h26, 8'h80, 8'h2E, 8'h01, 8'h56,
    8'h72, 8'h48, 8'h2E, 8'h02, 8'h71, 8'h7A, 8'hC6, 8'hA6, 8'h5F,
    8'h36, 8'hC3, 8'h6B, 8'h73, 8'h7E, 8'hC6, 8'h7F, 8'h77, 8'h76 };
  logic [7:0] prog2 [4] = '{ 8'h70, 8'h77, 8'h7F, 8'h01 };

  task automatic clear_mem();
    for (int a = 0; a < 256; a++) begin
      mem[a] = 8'h00; rmem[a] = 8'h00;
      mem[16'h8000 + a] = 8'h00; rmem[16'h8000 + a] = 8'h00;
    end
  endtask

  task automatic reset_core();
    cmp_on = 1'b0;
    rst_n  = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!halted && !illegal, "R1", "stop flags in reset",
          {halted, illegal}, 0);
    check(flags == 8'h00, "R1", "flags in reset", int'(flags), 0);
    check(!mem_wr, "R1", "write in reset", int'(mem_wr), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    cmp_on = 1'b1;
  endtask

  initial begin
    // run 1: every instruction form, ends on the stop opcode
    clear_mem();
    for (int i = 0; i < 36; i++) begin mem[i] = prog1[i]; rmem[i] = prog1[i]; end
    mem[16'h8001] = 8'h5A; rmem[16'h8001] = 8'h5A;
    model_reset();
    reset_core();
    check(mem_addr == 16'h0000 && mem_rd, "R1", "first fetch",
          int'(mem_addr), 0);
    repeat (140) @(posedge clk);
    @(negedge clk);
    check(mem[16'h8000] == 8'h7F, "R5", "store of A at 8000",
          int'(mem[16'h8000]), 8'h7F);
    check(mem[16'h8001] == 8'h5A, "R4", "load then store at 8001",
          int'(mem[16'h8001]), 8'h5A);
    check(mem[16'h8002] == 8'hC3, "R6", "immediate store at 8002",
          int'(mem[16'h8002]), 8'hC3);
    check(halted == 1'b1, "R9", "halted after stop", int'(halted), 1);
    check(flags == 8'h00, "R8", "flags after last add", int'(flags), 0);

    // run 2: reset values, then an unmatched opcode
    clear_mem();
    for (int i = 0; i < 4; i++) begin mem[i] = prog2[i]; rmem[i] = prog2[i]; end
    mem[16'h0000] = prog2[0]; mem[16'h00FF] = 8'hEE; rmem[16'h00FF] = 8'hEE;
    model_reset();
    reset_core();
    repeat (40) @(posedge clk);
    @(negedge clk);
    check(mem[16'h0000] == 8'h00, "R1", "reset B/A stored at 0000",
          int'(mem[16'h0000]), 0);
    check(illegal == 1'b1, "R10", "illegal after bad opcode", int'(illegal), 1);
    check(halted == 1'b0, "R10", "no halt on bad opcode", int'(halted), 0);
    check(!mem_rd && !mem_wr, "R10", "bus quiet after fault",
          {mem_rd, mem_wr}, 0);

    cmp_on = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL R2 watchdog expired: actual 0 expected 1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule